// File: doc/BRIEF.md
# MDIO Management Master with Register Port

This block lets software reach the management registers of Ethernet PHYs over the two-wire serial management bus. Software configures the clock divider and frame style once, loads a 16-bit word into the transmit-data register and then writes a command word. The write launches exactly one serial frame. The block generates MDC, drives the data line through a separate output and output-enable, and samples the returned bits on reads.

Two frame styles are supported, chosen by a mode bit in the clock-control register. The short style addresses a 5-bit register directly. The extended style reaches a device number and a 16-bit register address. For the extended style, software issues one address frame first and then a separate write or read frame. Progress is polled: both data registers show a busy flag while a frame is on the wire, and a done flag once it has finished.

Top module: `mdio_host`

## Requirements
- R1: Registers sit at byte offsets 0x00 (command), 0x08 (transmit data), 0x10 (receive data), 0x18 (clock control) and 0x20 (enable); the block decodes address bits [5:3] only. Reads return the stored data one cycle after the read strobe. The following fields read back as written: transmit data [15:0]; in clock control, the divider [7:0], the preamble switch at bit 12 and the extended-mode bit at bit 24; in the enable register, bit 0. All other bits read as zero.
- R2: The command word carries the register or device number in bits [4:0], the PHY address in [12:8] and the operation code in [17:16]. Writing a legal command while enabled and idle starts a frame, and bit 17 of both data registers then reads 1 until the frame ends.
- R3: With the mode bit clear, a frame starts with the start bits 01. Operation 0 goes on the wire as 01 and is a write. Operation 1 goes on the wire as 10 and is a read.
- R4: With the mode bit set, a frame starts with the start bits 00. Operation 0 is sent as 00 (address), operation 1 as 01 (write) and operation 3 as 11 (read). Operation 2 in this mode, and operations 2 and 3 in the short mode, start nothing.
- R5: The preamble switch adds 32 one bits ahead of the frame; when it is clear, the frame starts directly with the start bits. After the start bits come the 2 opcode bits, 5 PHY bits, 5 register bits, 2 turnaround bits and 16 data bits, each field sent MSB first.
- R6: Address and write frames send turnaround 10 and then the 16-bit transmit-data word, with the output-enable held high for the whole frame.
- R7: Read frames release the output-enable from the turnaround through the last data bit. The input is sampled on MDC rising edges during the 16 data bits. At frame end, the sampled word appears in receive data [15:0] and bit 16 of that register is set. Launching a read clears bit 16.
- R8: Each MDC half period lasts divider+1 system clocks. The data output changes only while MDC is low. When the block is idle, MDC and the output-enable are low.
- R9: A command written while a frame is in progress is ignored. No second frame follows.
- R10: While enable bit 0 is clear, commands are ignored. Clearing the bit in mid-frame stops the frame within two cycles: MDC and output-enable go low and busy clears, and no done flag is set.
- R11: After synchronous reset, all registers read zero, and MDC and output-enable are low.
- R12: When an address or write frame finishes, bit 16 of the transmit-data register is set. Launching another such frame clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_rd |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input |

## Verification
The bench decodes every frame off the wire at MDC rising edges. It compares the start, opcode and field bits against the requirements for every mode, operation and preamble setting. It also times each half period of MDC, so a divider that is off by one, or a first bit that is shortened, shows up as a mismatched minimum or maximum.

A simulated PHY returns known words with the top or bottom bit set. A shift in the wrong direction, or a capture that is one edge early, therefore corrupts the value read back. Other tests cover:
- commands issued while a frame is running, which would show up as a second burst of MDC edges;
- illegal opcodes, which would show up as a frame that should not exist;
- disabling the bus in mid-frame, which would leave MDC toggling or busy stuck.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W     = 6;
  localparam int REG_W      = 32;
  localparam int DATA_BITS  = 16;
  localparam int BODY_BITS  = 32;
  localparam int PRE_BITS   = 32;

  localparam logic [2:0] IDX_CMD  = 3'd0;
  localparam logic [2:0] IDX_WDAT = 3'd1;
  localparam logic [2:0] IDX_RDAT = 3'd2;
  localparam logic [2:0] IDX_CLK  = 3'd3;
  localparam logic [2:0] IDX_EN   = 3'd4;

  typedef struct packed {
    logic [1:0] op;
    logic [4:0] phy;
    logic [4:0] dev;
    logic       rd;
  } cmd_t;

  // returns {legal, wire_opcode[1:0]}
  function automatic logic [2:0] map_op(input logic ext, input logic [1:0] op);
    logic [2:0] r;
    r = 3'b000;
    if (!ext) begin
      if (op == 2'd0)      r = 3'b101;
      else if (op == 2'd1) r = 3'b110;
    end else begin
      if (op == 2'd0)      r = 3'b100;
      else if (op == 2'd1) r = 3'b101;
      else if (op == 2'd3) r = 3'b111;
    end
    return r;
  endfunction
endpackage

// File: rtl/mdio_tick.sv
module mdio_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  // R8: a divider above zero never yields back-to-back ticks
  p_tick_gap_r8: assert property (@(posedge clk) disable iff (rst)
    (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame #(
  parameter int PRE_BITS  = 32,
  parameter int BODY_BITS = 32,
  parameter int DATA_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 abort,
  input  logic                 start,
  input  logic                 pre_en,
  input  logic [BODY_BITS-1:0] body,
  input  logic                 is_read,
  input  logic                 tick,
  input  logic                 mdi,
  output logic                 mdc,
  output logic                 mdo,
  output logic                 oe,
  output logic                 busy,
  output logic                 done,
  output logic [DATA_BITS-1:0] rdata
);
  localparam int TOT        = PRE_BITS + BODY_BITS;
  localparam int CNT_W      = $clog2(TOT + 1);
  localparam int DATA_START = BODY_BITS - DATA_BITS;
  localparam int TURN_POS   = DATA_START - 2;

  logic [TOT-1:0]   sh;
  logic [CNT_W-1:0] bitn, last, offs;
  logic             rd;
  logic             in_data, next_rel;

  assign in_data  = rd && (bitn >= offs + CNT_W'(DATA_START));
  assign next_rel = rd && ((bitn + 1'b1) >= offs + CNT_W'(TURN_POS));

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst || abort) begin
      busy <= 1'b0; mdc <= 1'b0; mdo <= 1'b0; oe <= 1'b0;
      bitn <= '0; last <= '0; offs <= '0; rd <= 1'b0; sh <= '0;
      if (rst) rdata <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      mdc  <= 1'b0;
      oe   <= 1'b1;
      rd   <= is_read;
      bitn <= '0;
      offs <= pre_en ? CNT_W'(PRE_BITS) : '0;
      last <= pre_en ? CNT_W'(TOT - 1) : CNT_W'(BODY_BITS - 1);
      sh   <= pre_en ? {{PRE_BITS{1'b1}}, body} : {body, {PRE_BITS{1'b0}}};
      mdo  <= pre_en ? 1'b1 : body[BODY_BITS-1];
    end else if (busy && tick) begin
      if (!mdc) begin
        mdc <= 1'b1;
        if (in_data) rdata <= {rdata[DATA_BITS-2:0], mdi};
      end else begin
        mdc <= 1'b0;
        if (bitn == last) begin
          busy <= 1'b0;
          done <= 1'b1;
          oe   <= 1'b0;
        end else begin
          bitn <= bitn + 1'b1;
          sh   <= sh << 1;
          mdo  <= sh[TOT-2];
          oe   <= !next_rel;
        end
      end
    end
  end

  // R8: idle lines are quiet
  p_idle_lines_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !oe));
  // R8: data output never moves while the clock is high
  p_mdo_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && mdc) |-> $stable(mdo));
  // R7: line released during read data bits
  p_read_release_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && in_data) |-> !oe);
endmodule

// File: rtl/mdio_host.sv
module mdio_host
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic [2:0]           idx;
  cmd_t                 cmd_q;
  logic [DATA_BITS-1:0] wdat_q, rdat_q, cap;
  logic [DIV_W-1:0]     div_q;
  logic                 pre_q, ext_q, en_q, rd_valid, wr_valid;
  logic                 busy, done, tick, launch;
  logic [2:0]           opm;
  logic [BODY_BITS-1:0] body;
  logic [REG_W-1:0]     rmux;

  assign idx    = reg_addr[ADDR_W-1:3];
  assign opm    = map_op(ext_q, reg_wdata[17:16]);
  assign launch = reg_wr && idx == IDX_CMD && en_q && !busy && opm[2];
  assign body   = {(ext_q ? 2'b00 : 2'b01), opm[1:0], reg_wdata[12:8], reg_wdata[4:0],
                   (opm[1] ? 2'b00 : 2'b10), (opm[1] ? {DATA_BITS{1'b0}} : wdat_q)};

  mdio_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .run(busy), .div(div_q), .tick(tick));

  mdio_frame #(.PRE_BITS(PRE_BITS), .BODY_BITS(BODY_BITS), .DATA_BITS(DATA_BITS)) u_frame (
    .clk(clk), .rst(rst), .abort(!en_q), .start(launch), .pre_en(pre_q),
    .body(body), .is_read(opm[1]), .tick(tick), .mdi(mdio_i),
    .mdc(mdc), .mdo(mdio_o), .oe(mdio_oe), .busy(busy), .done(done), .rdata(cap));

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0; wdat_q <= '0; rdat_q <= '0; div_q <= '0;
      pre_q <= 1'b0; ext_q <= 1'b0; en_q <= 1'b0;
      rd_valid <= 1'b0; wr_valid <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (idx)
          IDX_WDAT: wdat_q <= reg_wdata[DATA_BITS-1:0];
          IDX_CLK: begin
            div_q <= reg_wdata[DIV_W-1:0];
            pre_q <= reg_wdata[12];
            ext_q <= reg_wdata[24];
          end
          IDX_EN:  en_q <= reg_wdata[0];
          default: ;
        endcase
      end
      if (launch) begin
        cmd_q <= '{op: reg_wdata[17:16], phy: reg_wdata[12:8], dev: reg_wdata[4:0], rd: opm[1]};
        if (opm[1]) rd_valid <= 1'b0;
        else        wr_valid <= 1'b0;
      end
      if (done) begin
        if (cmd_q.rd) begin
          rd_valid <= 1'b1;
          rdat_q   <= cap;
        end else begin
          wr_valid <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    rmux = '0;
    case (idx)
      IDX_CMD: begin
        rmux[17:16] = cmd_q.op;
        rmux[12:8]  = cmd_q.phy;
        rmux[4:0]   = cmd_q.dev;
      end
      IDX_WDAT: rmux = {14'b0, busy, wr_valid, wdat_q};
      IDX_RDAT: rmux = {14'b0, busy, rd_valid, rdat_q};
      IDX_CLK: begin
        rmux[DIV_W-1:0] = div_q;
        rmux[12]        = pre_q;
        rmux[24]        = ext_q;
      end
      IDX_EN:  rmux[0] = en_q;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rmux;
  end

  // R9: the command held for a running frame cannot be replaced
  p_cmd_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cmd_q));
  // R10: a disabled bus is idle one cycle later
  p_disable_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !busy);
  // R7: receive flag rises only as the frame ends
  p_valid_at_end_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_valid) |-> !busy);
endmodule

// File: tb/mdio_host_bench.sv
module mdio_host_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int total = 0, bad = 0;

  mdio_host u_mdio_host (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #5 clk = ~clk;

  // vector: [37]ext [36]pre [35:34]op [33:29]phy [28:24]reg [23:8]data/resp [7:0]divider
  localparam logic [37:0] VEC [6] = '{
    {1'b0, 1'b1, 2'd0, 5'd5,  5'h1A, 16'hA5C3, 8'd1},
    {1'b0, 1'b0, 2'd1, 5'h1F, 5'd3,  16'h1234, 8'd0},
    {1'b1, 1'b1, 2'd0, 5'd2,  5'd1,  16'h8001, 8'd2},
    {1'b1, 1'b0, 2'd1, 5'h10, 5'd7,  16'hFFFE, 8'd0},
    {1'b1, 1'b1, 2'd3, 5'd1,  5'h1E, 16'h0F0F, 8'd3},
    {1'b0, 1'b0, 2'd1, 5'd0,  5'd0,  16'h8000, 8'd0}
  };

  // line monitor and PHY model
  logic        mdc_prev = 1'b0;
  int          cyc = 0, last_edge = 0, edges = 0, rises = 0, hmin = 9999, hmax = 0;
  logic [63:0] capb = '0, capoe = '0;
  logic [15:0] phy_resp = '0;
  int          phy_off = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (mdc !== mdc_prev) begin
      if (edges > 0) begin
        if (cyc - last_edge < hmin) hmin = cyc - last_edge;
        if (cyc - last_edge > hmax) hmax = cyc - last_edge;
      end
      edges = edges + 1;
      last_edge = cyc;
      if (mdc) begin
        capb  = {capb[62:0], mdio_o};
        capoe = {capoe[62:0], mdio_oe};
        rises = rises + 1;
      end else begin
        if (rises - phy_off - 16 >= 0 && rises - phy_off - 16 < 16)
          mdio_i = phy_resp[15 - (rises - phy_off - 16)];
        else
          mdio_i = 1'b0;
      end
    end
    mdc_prev = mdc;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic mon_clear();
    rises = 0; edges = 0; hmin = 9999; hmax = 0; capb = '0; capoe = '0;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int k = 0; k < 3000; k++) begin
      rd(6'h08, d);
      if (!d[17]) break;
    end
  endtask

  function automatic logic [1:0] wire_op(input logic ext, input logic [1:0] op);
    if (!ext) return (op == 2'd0) ? 2'b01 : 2'b10;
    return op;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired, run hung");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] body;
    logic [63:0] expb, expoe, mask;
    logic        ext, pre, isrd;
    logic [1:0]  op;
    logic [15:0] dat;
    logic [7:0]  ph;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R11 lines", {62'b0, mdc, mdio_oe}, 64'h0);
    rd(6'h08, d); chk(d == 32'h0, "R11 txdata", 64'(d), 64'h0);
    rd(6'h10, d); chk(d == 32'h0, "R11 rxdata", 64'(d), 64'h0);
    rd(6'h18, d); chk(d == 32'h0, "R11 clkctl", 64'(d), 64'h0);
    rd(6'h20, d); chk(d == 32'h0, "R11 enable", 64'(d), 64'h0);
    // R1: field read-back
    wr(6'h18, 32'hFFFF_FFFF); rd(6'h18, d);
    chk(d == 32'h0100_10FF, "R1 clkctl fields", 64'(d), 64'h0100_10FF);
    wr(6'h08, 32'hFFFF_BEEF); rd(6'h08, d);
    chk(d == 32'h0000_BEEF, "R1 txdata fields", 64'(d), 64'h0000_BEEF);
    // R10: disabled bus ignores commands
    wr(6'h18, 32'h0); mon_clear();
    wr(6'h00, 32'h0000_0101);
    repeat (100) @(negedge clk);
    rd(6'h08, d);
    chk(rises == 0 && !d[17], "R10 disabled ignores cmd", 64'(rises), 64'h0);
    wr(6'h20, 32'hFFFF_FFFF); rd(6'h20, d);
    chk(d == 32'h1, "R1 enable field", 64'(d), 64'h1);

    // table-driven frames: R2 R3 R4 R5 R6 R7 R8 R12
    for (int i = 0; i < 6; i++) begin
      {ext, pre, op} = VEC[i][37:34];
      dat = VEC[i][23:8];
      ph  = VEC[i][7:0];
      isrd = (wire_op(ext, op) == 2'b10) || (wire_op(ext, op) == 2'b11);
      wr(6'h18, {7'b0, ext, 11'b0, pre, 4'b0, ph});
      wr(6'h08, {16'b0, dat});
      phy_resp = dat;
      phy_off = pre ? 32 : 0;
      mon_clear();
      wr(6'h00, {14'b0, op, 3'b0, VEC[i][33:29], 3'b0, VEC[i][28:24]});
      rd(6'h10, d);
      chk(d[17] == 1'b1, "R2 busy after launch", 64'(d), 64'h2_0000);
      wait_idle();
      body = {(ext ? 2'b00 : 2'b01), wire_op(ext, op), VEC[i][33:29], VEC[i][28:24], 2'b10, dat};
      expb  = pre ? {32'hFFFF_FFFF, body} : {32'h0, body};
      mask  = isrd ? (pre ? 64'hFFFF_FFFF_FFFC_0000 : 64'h0000_0000_FFFC_0000) : 64'hFFFF_FFFF_FFFF_FFFF;
      expoe = (pre ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF) & (isrd ? ~64'h3_FFFF : ~64'h0);
      chk(rises == (pre ? 64 : 32), "R5 bit count", 64'(rises), pre ? 64'd64 : 64'd32);
      chk((capb & mask) == (expb & mask), ext ? "R4 R5 ext frame bits" : "R3 R5 short frame bits",
          capb & mask, expb & mask);
      chk(capoe == expoe, isrd ? "R7 oe release" : "R6 oe held", capoe, expoe);
      chk(hmin == int'(ph) + 1 && hmax == int'(ph) + 1, "R8 half period",
          {32'(hmin), 32'(hmax)}, {32'(ph + 1), 32'(ph + 1)});
      if (isrd) begin
        rd(6'h10, d);
        chk(d == {15'b0, 1'b1, dat}, "R7 rx data and flag", 64'(d), 64'({15'b0, 1'b1, dat}));
      end else begin
        rd(6'h08, d);
        chk(d == {15'b0, 1'b1, dat}, "R12 tx done flag", 64'(d), 64'({15'b0, 1'b1, dat}));
      end
      chk(mdc == 1'b0 && mdio_oe == 1'b0, "R8 idle lines", {62'b0, mdc, mdio_oe}, 64'h0);
    end

    // R12: launching a write clears the done flag
    wr(6'h18, 32'h0000_0003); wr(6'h08, 32'h0000_00FF);
    wr(6'h00, 32'h0000_0101); rd(6'h08, d);
    chk(d[16] == 1'b0 && d[17] == 1'b1, "R12 flag cleared at launch", 64'(d[17:16]), 64'h2);
    wait_idle();

    // R9: command during a frame is ignored
    wr(6'h18, 32'h0); wr(6'h08, 32'h0000_00FF); mon_clear();
    wr(6'h00, 32'h0000_0102);
    wr(6'h00, 32'h0001_0304);
    wait_idle();
    repeat (100) @(negedge clk);
    chk(rises == 32, "R9 single frame", 64'(rises), 64'd32);
    chk(capb[31:0] == {2'b01, 2'b01, 5'd1, 5'd2, 2'b10, 16'h00FF}, "R9 first frame kept",
        capb, {32'h0, 2'b01, 2'b01, 5'd1, 5'd2, 2'b10, 16'h00FF});
    rd(6'h00, d);
    chk(d == 32'h0000_0102, "R2 command fields", 64'(d), 64'h0000_0102);

    // R4: illegal opcodes start nothing
    mon_clear(); wr(6'h00, 32'h0002_0101);
    repeat (60) @(negedge clk); rd(6'h08, d);
    chk(rises == 0 && !d[17], "R4 short op2 ignored", 64'(rises), 64'h0);
    wr(6'h18, 32'h0100_0000); mon_clear(); wr(6'h00, 32'h0002_0101);
    repeat (60) @(negedge clk); rd(6'h08, d);
    chk(rises == 0 && !d[17], "R4 ext op2 ignored", 64'(rises), 64'h0);
    wr(6'h18, 32'h0); mon_clear(); wr(6'h00, 32'h0003_0101);
    repeat (60) @(negedge clk); rd(6'h08, d);
    chk(rises == 0 && !d[17], "R4 short op3 ignored", 64'(rises), 64'h0);

    // R10: clearing enable mid-frame aborts
    wr(6'h18, 32'h0000_1003); mon_clear();
    wr(6'h00, 32'h0001_0101);
    repeat (100) @(negedge clk);
    wr(6'h20, 32'h0);
    repeat (2) @(negedge clk);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R10 abort lines", {62'b0, mdc, mdio_oe}, 64'h0);
    rd(6'h10, d);
    chk(d[17:16] == 2'b00, "R10 abort busy and flag", 64'(d[17:16]), 64'h0);
    begin
      int r0;
      r0 = rises;
      repeat (200) @(negedge clk);
      chk(rises == r0, "R10 no edges after abort", 64'(rises), 64'(r0));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule